// File: doc/BRIEF.md
# Transfer Group Event Flag Controller

This block holds the event flags of one data transfer group and turns them into an interrupt. Four events are sticky: count expiry, a wait condition, and a primary and a secondary terminal count. Each is set by a one-cycle pulse and stays set until software clears it. A fifth event, transfer ready, is a live copy of the FIFO-not-empty input and cannot be cleared.

Software reaches the block over a byte-wide synchronous register bus with an address, a write strobe, write data and combinational read data. Sticky flags are cleared through two write-to-clear registers. The wait and both terminal-count flags are in the first clear register. Count expiry is in the second, so a broad clear of the first register never loses the end-of-transfer event. The first clear register also issues one-cycle DMA-reset and FIFO-reset pulses to the neighbouring logic.

A loadable down-counter counts completed transfers and raises count expiry when it reaches zero. The interrupt is the registered OR of the enabled flags. It is gated by a two-bit line-select field in a master control register; the value zero turns the interrupt off.

Top module: `xfer_evt_ctrl`

Register map (byte addresses): 0 = flags (read) / first clear (write); 1 = status (read) / second clear (write); 2 = interrupt enable; 3 = master control; 4..7 = transfer count, least significant byte at 4. Other addresses read as 0x00.

## Requirements
- R1: After reset, every sticky flag, the interrupt-enable register, the master control register and the transfer count read zero, and irq_o, dma_rst_o and fifo_rst_o are low.
- R2: A pulse on waited_pulse_i, ptc_pulse_i or stc_pulse_i sets flag bit 5, 6 or 7 respectively at the next clock edge. The flag stays set until it is cleared.
- R3: Writing the first clear register (address 0) with bit 3, bit 4 or bit 5 set clears the waited, primary or secondary terminal-count flag respectively. Other flags are not changed.
- R4: Writing address 0 with bit 6 set gives one cycle of dma_rst_o, and with bit 7 set one cycle of fifo_rst_o, in the cycle after the write. Writing 0xFF clears flag bits 5 to 7 and gives both pulses.
- R5: The count-expired flag (flag bit 1) is cleared only by writing bit 0 of the second clear register (address 1). Writes to address 0 do not clear it.
- R6: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R7: Flag bit 0 (transfer ready) equals fifo_nempty_i in the same cycle and no clear write affects it.
- R8: The transfer count occupies addresses 4..7, least significant byte first, and reads back. Each xfer_done_i pulse decrements a nonzero count. A decrement from 1 to 0 sets the count-expired flag at the same edge. A pulse while the count is 0 leaves it at 0.
- R9: The interrupt-enable register (address 2) uses the flag bit positions. One cycle after its cause, irq_o is high when any enabled flag is set and master control bits [1:0] are nonzero. irq_sel_o shows master bits [1:0].
- R10: The status register reads bit 0 = any flag (including transfer ready) set, bit 2 = req_i, bit 3 = stop_trig_i, and all other bits zero.
- R11: A write to any count byte in the same cycle as an xfer_done_i pulse takes the written value and performs no decrement and no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| fifo_nempty_i | input | 1 | FIFO holds data (transfer ready) |
| waited_pulse_i | input | 1 | Wait event pulse |
| ptc_pulse_i | input | 1 | Primary terminal count pulse |
| stc_pulse_i | input | 1 | Secondary terminal count pulse |
| xfer_done_i | input | 1 | One transfer completed |
| req_i | input | 1 | Request line level |
| stop_trig_i | input | 1 | Stop trigger level |
| irq_o | output | 1 | Registered group interrupt |
| irq_sel_o | output | 2 | Selected interrupt line, 0 = off |
| dma_rst_o | output | 1 | One-cycle DMA reset request |
| fifo_rst_o | output | 1 | One-cycle FIFO reset request |

## Verification
The assertions assume that event inputs and the bus are synchronous to clk and stable around the edge. They also assume that a cleared flag can only have been cleared by a register write seen on the bus in the previous cycle. The stimulus drives every input on the falling edge. Event pulses are random single-cycle levels that may coincide with clears of the same flag. Count bytes above the lowest are mostly written as zero, so counts stay small and expiry occurs within the run.

// File: rtl/xfer_evt_pkg.sv
package xfer_evt_pkg;

   localparam int unsigned REG_W = 8;

   // register addresses
   localparam int unsigned A_FLAG_CLR1 = 0;
   localparam int unsigned A_STAT_CLR2 = 1;
   localparam int unsigned A_IRQ_EN    = 2;
   localparam int unsigned A_MASTER    = 3;
   localparam int unsigned A_COUNT0    = 4;

   // flag bit positions (shared by the enable register)
   localparam int unsigned FB_XRDY = 0;
   localparam int unsigned FB_CEXP = 1;
   localparam int unsigned FB_WAIT = 5;
   localparam int unsigned FB_PTC  = 6;
   localparam int unsigned FB_STC  = 7;

   // first clear register bits
   localparam int unsigned C1_WAIT = 3;
   localparam int unsigned C1_PTC  = 4;
   localparam int unsigned C1_STC  = 5;
   localparam int unsigned C1_DMA  = 6;
   localparam int unsigned C1_FIFO = 7;

   // second clear register bit
   localparam int unsigned C2_CEXP = 0;

   // status bits
   localparam int unsigned SB_PEND = 0;
   localparam int unsigned SB_REQ  = 2;
   localparam int unsigned SB_STOP = 3;

   // sticky flag slots
   typedef enum logic [1:0] {
      SLOT_CEXP = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_PTC  = 2'd2,
      SLOT_STC  = 2'd3
   } sticky_slot_e;

   localparam int unsigned N_STICKY = 4;

   function automatic int unsigned slot_flag_pos(input int unsigned slot);
      case (slot)
         0:       return FB_CEXP;
         1:       return FB_WAIT;
         2:       return FB_PTC;
         default: return FB_STC;
      endcase
   endfunction

endpackage

// File: rtl/evt_sticky_flag.sv
module evt_sticky_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_priority
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_clr_priority
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;

endmodule

// File: rtl/xfer_down_counter.sv
module xfer_down_counter #(
   parameter int unsigned CNT_W = 32,
   localparam int unsigned NB   = CNT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NB-1:0]    byte_we_i,
   input  logic [7:0]       byte_d_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             any_we;
   logic             at_zero;
   logic             at_one;

   assign any_we  = |byte_we_i;
   assign at_zero = (cnt_q == '0);
   assign at_one  = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (any_we) begin
         for (int k = 0; k < NB; k++) begin
            if (byte_we_i[k]) cnt_q[k*8 +: 8] <= byte_d_i;
         end
      end else if (dec_i && !at_zero) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = dec_i && at_one && !any_we;
   assign count_o  = cnt_q;

endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
   parameter int unsigned N_FLAGS = 8,
   parameter int unsigned SEL_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] flags_i,
   input  logic [N_FLAGS-1:0] enable_i,
   input  logic [SEL_W-1:0]   line_sel_i,
   output logic               irq_o
);

   logic irq_q;
   logic raw_req;

   assign raw_req = |(flags_i & enable_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= raw_req && (line_sel_i != '0);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/xfer_evt_ctrl.sv
module xfer_evt_ctrl
   import xfer_evt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CNT_W    = 32,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              fifo_nempty_i,
   input  logic              waited_pulse_i,
   input  logic              ptc_pulse_i,
   input  logic              stc_pulse_i,
   input  logic              xfer_done_i,
   input  logic              req_i,
   input  logic              stop_trig_i,
   output logic              irq_o,
   output logic [1:0]        irq_sel_o,
   output logic              dma_rst_o,
   output logic              fifo_rst_o
);

   localparam int unsigned NB        = CNT_W / 8;
   localparam int unsigned LAST_ADDR = A_COUNT0 + NB - 1;

   generate
      if ((CNT_W % 8) != 0 || CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must be a nonzero multiple of 8");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the count bytes");
      end
   endgenerate

   // address decode
   logic wr_clr1, wr_clr2, wr_ien, wr_mst;
   logic [NB-1:0] cnt_we;

   assign wr_clr1 = bus_wr && (bus_addr == ADDR_W'(A_FLAG_CLR1));
   assign wr_clr2 = bus_wr && (bus_addr == ADDR_W'(A_STAT_CLR2));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IRQ_EN));
   assign wr_mst  = bus_wr && (bus_addr == ADDR_W'(A_MASTER));

   genvar gb;
   generate
      for (gb = 0; gb < NB; gb++) begin : g_cnt_dec
         assign cnt_we[gb] = bus_wr && (bus_addr == ADDR_W'(A_COUNT0 + gb));
      end
   endgenerate

   // transfer counter
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_expire;

   xfer_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we_i (cnt_we),
      .byte_d_i  (bus_wdata),
      .dec_i     (xfer_done_i),
      .count_o   (cnt_q),
      .expire_o  (cnt_expire)
   );

   // sticky flags
   logic [N_STICKY-1:0] st_set, st_clr, st_q;

   assign st_set[SLOT_CEXP] = cnt_expire;
   assign st_set[SLOT_WAIT] = waited_pulse_i;
   assign st_set[SLOT_PTC]  = ptc_pulse_i;
   assign st_set[SLOT_STC]  = stc_pulse_i;

   assign st_clr[SLOT_CEXP] = wr_clr2 && bus_wdata[C2_CEXP];
   assign st_clr[SLOT_WAIT] = wr_clr1 && bus_wdata[C1_WAIT];
   assign st_clr[SLOT_PTC]  = wr_clr1 && bus_wdata[C1_PTC];
   assign st_clr[SLOT_STC]  = wr_clr1 && bus_wdata[C1_STC];

   logic [REG_W-1:0] flag_vec;
   logic [REG_W-1:0] sticky_map [N_STICKY];

   genvar gs;
   generate
      for (gs = 0; gs < N_STICKY; gs++) begin : g_sticky
         evt_sticky_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (st_set[gs]),
            .clr_i  (st_clr[gs]),
            .flag_o (st_q[gs])
         );
         assign sticky_map[gs] = REG_W'(st_q[gs]) << slot_flag_pos(gs);
      end
   endgenerate

   always_comb begin
      flag_vec = '0;
      flag_vec[FB_XRDY] = fifo_nempty_i;
      for (int i = 0; i < N_STICKY; i++) flag_vec = flag_vec | sticky_map[i];
   end

   // control registers and reset pulses
   logic [REG_W-1:0] ien_q;
   logic [1:0]       mst_q;
   logic             dma_q, fifo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         mst_q  <= '0;
         dma_q  <= 1'b0;
         fifo_q <= 1'b0;
      end else begin
         if (wr_ien) ien_q <= bus_wdata;
         if (wr_mst) mst_q <= bus_wdata[1:0];
         dma_q  <= wr_clr1 && bus_wdata[C1_DMA];
         fifo_q <= wr_clr1 && bus_wdata[C1_FIFO];
      end
   end

   assign dma_rst_o  = dma_q;
   assign fifo_rst_o = fifo_q;
   assign irq_sel_o  = mst_q;

   evt_irq_gen #(.N_FLAGS(REG_W), .SEL_W(2)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flags_i    (flag_vec),
      .enable_i   (ien_q),
      .line_sel_i (mst_q),
      .irq_o      (irq_o)
   );

   // status and read mux
   logic [REG_W-1:0] stat_vec;

   always_comb begin
      stat_vec = '0;
      stat_vec[SB_PEND] = |flag_vec;
      stat_vec[SB_REQ]  = req_i;
      stat_vec[SB_STOP] = stop_trig_i;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_FLAG_CLR1))      bus_rdata = flag_vec;
      else if (bus_addr == ADDR_W'(A_STAT_CLR2)) bus_rdata = stat_vec;
      else if (bus_addr == ADDR_W'(A_IRQ_EN))    bus_rdata = ien_q;
      else if (bus_addr == ADDR_W'(A_MASTER))    bus_rdata = {6'b0, mst_q};
      else begin
         for (int k = 0; k < NB; k++) begin
            if (bus_addr == ADDR_W'(A_COUNT0 + k)) bus_rdata = cnt_q[k*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/xfer_evt_ctrl_chk.sv
module xfer_evt_ctrl_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        flags,
   input logic [CNT_W-1:0]  count,
   input logic              waited_pulse_i,
   input logic              xfer_done_i,
   input logic              irq_o,
   input logic [1:0]        irq_sel_o,
   input logic              dma_rst_o
);

   localparam int unsigned NB = CNT_W / 8;

   logic cnt_wr;
   assign cnt_wr = bus_wr && (int'(bus_addr) >= 4) && (int'(bus_addr) < 4 + NB);

   // R6: set beats clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      waited_pulse_i |=> flags[5]);

   // R2: flag held unless its clear bit is written
   a_r2_waited_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[5] && !(bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[3])) |=> flags[5]);

   // R5: count expired falls only after a second-clear write
   a_r5_cexp_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[1]) |-> $past(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0]));

   // R4: DMA reset pulse has a cause
   a_r4_dma_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rst_o |-> $past(bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[6]));

   // R9: interrupt needs a nonzero line select
   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(irq_sel_o) != 2'b00));

   // R8: no underflow
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && xfer_done_i && !cnt_wr) |=> (count == '0));

   // R8: reaching zero raises count expired
   a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(1) && xfer_done_i && !cnt_wr) |=> flags[1]);

endmodule

bind xfer_evt_ctrl xfer_evt_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_wr         (bus_wr),
   .bus_wdata      (bus_wdata),
   .flags          (flag_vec),
   .count          (cnt_q),
   .waited_pulse_i (waited_pulse_i),
   .xfer_done_i    (xfer_done_i),
   .irq_o          (irq_o),
   .irq_sel_o      (irq_sel_o),
   .dma_rst_o      (dma_rst_o)
);

// File: tb/tb_xfer_evt_ctrl.sv
module tb_xfer_evt_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       fne = 1'b0, wp = 1'b0, pp = 1'b0, sp = 1'b0, dn = 1'b0, rq = 1'b0, st = 1'b0;
   logic       irq_o, dma_rst_o, fifo_rst_o;
   logic [1:0] irq_sel_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   xfer_evt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_nempty_i(fne),
      .waited_pulse_i(wp), .ptc_pulse_i(pp), .stc_pulse_i(sp),
      .xfer_done_i(dn), .req_i(rq), .stop_trig_i(st), .irq_o(irq_o),
      .irq_sel_o(irq_sel_o), .dma_rst_o(dma_rst_o), .fifo_rst_o(fifo_rst_o)
   );

   // reference state
   logic        m_w = 0, m_p = 0, m_s = 0, m_c = 0, m_irq = 0, m_dma = 0, m_fifo = 0;
   logic [7:0]  m_ie = 0;
   logic [1:0]  m_ms = 0;
   logic [31:0] m_cnt = 0;

   function automatic logic [7:0] flagv(input logic f);
      return {m_s, m_p, m_w, 3'b000, m_c, f};
   endfunction

   function automatic logic [7:0] exp_rd(input logic [3:0] a, input logic f,
                                         input logic r, input logic t);
      case (a)
         4'd0: return flagv(f);
         4'd1: return {4'b0, t, r, 1'b0, |flagv(f)};
         4'd2: return m_ie;
         4'd3: return {6'b0, m_ms};
         4'd4: return m_cnt[7:0];
         4'd5: return m_cnt[15:8];
         4'd6: return m_cnt[23:16];
         4'd7: return m_cnt[31:24];
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle, entered and left at a falling edge
   task automatic cyc(input string tag, input logic wr, input logic [3:0] a,
                      input logic [7:0] d, input logic f, input logic w,
                      input logic p, input logic s, input logic dd,
                      input logic r, input logic t);
      logic cw, c1, c2, exp_set;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      fne = f; wp = w; pp = p; sp = s; dn = dd; rq = r; st = t;
      #1;
      if (!wr) chk(tag, bus_rdata, exp_rd(a, f, r, t));
      @(posedge clk);
      c1 = wr && a == 4'd0;
      c2 = wr && a == 4'd1;
      cw = wr && a >= 4'd4 && a <= 4'd7;
      m_irq = (m_ms != 0) && |(flagv(f) & m_ie);
      m_dma = c1 && d[6];
      m_fifo = c1 && d[7];
      exp_set = dd && m_cnt == 1 && !cw;
      m_w = w | (m_w & !(c1 && d[3]));
      m_p = p | (m_p & !(c1 && d[4]));
      m_s = s | (m_s & !(c1 && d[5]));
      m_c = exp_set | (m_c & !(c2 && d[0]));
      if (cw) m_cnt[(a - 4) * 8 +: 8] = d;
      else if (dd && m_cnt != 0) m_cnt = m_cnt - 1;
      if (wr && a == 4'd2) m_ie = d;
      if (wr && a == 4'd3) m_ms = d[1:0];
      @(negedge clk);
      chk("R9 irq", irq_o, m_irq);
      chk("R9 sel", irq_sel_o, m_ms);
      chk("R4 dma", dma_rst_o, m_dma);
      chk("R4 fifo", fifo_rst_o, m_fifo);
      bus_wr = 0; wp = 0; pp = 0; sp = 0; dn = 0;
   endtask

   task automatic rd(input string tag, input logic [3:0] a);
      cyc(tag, 0, a, 0, fne, 0, 0, 0, 0, rq, st);
   endtask

   task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
      cyc(tag, 1, a, d, fne, 0, 0, 0, 0, rq, st);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         bus_addr = 4'(a); #1;
         chk("R1", bus_rdata, 8'h00);
         @(negedge clk);
      end
      chk("R1 irq", irq_o, 0);
      chk("R1 dma", dma_rst_o, 0);
      // R7 live transfer ready, not clearable
      fne = 1; rd("R7", 0);
      wr("R7", 0, 8'hFF);
      bus_addr = 0; #1; chk("R7", bus_rdata[0], 1'b1); @(negedge clk);
      fne = 0; rd("R7", 0);
      // R2 sticky set and hold
      cyc("R2", 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
      rd("R2", 0); rd("R2", 0);
      bus_addr = 0; #1; chk("R2", bus_rdata, 8'hE0); @(negedge clk);
      // R3 selective clear
      wr("R3", 0, 8'h08);
      bus_addr = 0; #1; chk("R3", bus_rdata, 8'hC0); @(negedge clk);
      // R6 set wins
      cyc("R6", 1, 0, 8'h08, 0, 1, 0, 0, 0, 0, 0);
      bus_addr = 0; #1; chk("R6", bus_rdata[5], 1'b1); @(negedge clk);
      // R8 count down and expiry
      wr("R8", 4, 8'h02);
      cyc("R8", 0, 4, 0, 0, 0, 0, 0, 1, 0, 0);
      cyc("R8", 0, 4, 0, 0, 0, 0, 0, 1, 0, 0);
      bus_addr = 0; #1; chk("R8", bus_rdata[1], 1'b1); @(negedge clk);
      cyc("R8", 0, 4, 0, 0, 0, 0, 0, 1, 0, 0);
      bus_addr = 4; #1; chk("R8", bus_rdata, 8'h00); @(negedge clk);
      // R4 and R5: broad clear keeps count expiry, gives pulses
      wr("R4", 0, 8'hFF);
      chk("R4", dma_rst_o & fifo_rst_o, 1'b1);
      rd("R4", 0);
      chk("R4", dma_rst_o | fifo_rst_o, 1'b0);
      bus_addr = 0; #1; chk("R5", bus_rdata, 8'h02); @(negedge clk);
      wr("R5", 1, 8'h01);
      bus_addr = 0; #1; chk("R5", bus_rdata[1], 1'b0); @(negedge clk);
      // R11 write beats decrement
      wr("R11", 4, 8'h01);
      cyc("R11", 1, 4, 8'h05, 0, 0, 0, 0, 1, 0, 0);
      bus_addr = 4; #1; chk("R11", bus_rdata, 8'h05); @(negedge clk);
      bus_addr = 0; #1; chk("R11", bus_rdata[1], 1'b0); @(negedge clk);
      // R9 masking and master gate
      wr("R9", 2, 8'h40);
      cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      rd("R9", 0); chk("R9", irq_o, 1'b0);
      wr("R9", 3, 8'h01);
      rd("R9", 0); chk("R9", irq_o, 1'b1);
      wr("R9", 2, 8'h00);
      rd("R9", 0); chk("R9", irq_o, 1'b0);
      // R10 status
      rq = 1; st = 1;
      rd("R10", 1);
      bus_addr = 1; #1; chk("R10", bus_rdata, 8'h0D); @(negedge clk);
      rq = 0; st = 0;
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic        w_en;
         logic [3:0]  a;
         logic [7:0]  d;
         string       tg;
         w_en = ($urandom_range(0, 4) == 0);
         a = 4'($urandom_range(0, 8));
         d = 8'($urandom);
         if (a == 4) d = 8'($urandom_range(0, 6));
         else if (a > 4 && a < 8 && $urandom_range(0, 7) != 0) d = 0;
         case (a)
            4'd0: tg = "R2";
            4'd1: tg = "R10";
            4'd2, 4'd3: tg = "R9";
            default: tg = "R8";
         endcase
         cyc(tg, w_en, a, d, 1'($urandom_range(0, 1)),
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
             $urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule